// File: doc/BRIEF.md
# Label Filter and Receive Word FIFO

This block sits behind a serial receive validator. Each cycle that the validator strobes a finished 32-bit word, the block checks the word. It can compare the word's 8-bit label against a table of 16 programmable labels. It can also require that the two bits following the label equal two configured values. A word that passes every check that is turned on goes into a 32-deep FIFO. The host drains the FIFO over a 16-bit bus, one half-word at a time.

Three flags give the fill state: ready, half and full. The label table has a sequenced mode for loading and for reading back. While the mode bit is high, host writes fill the table and host reads return its entries in order. Word reception pauses during this mode.

The control bits are plain inputs, driven from a register elsewhere. Serial bit 1 of a word is `rx_word[0]` and bit 32 is `rx_word[31]`.

Top module: `rxf_label_fifo`

## Requirements
- R1: When `lbl_match_en` is 1, the label in `rx_word[7:0]` is compared with all 16 table entries, and a word with no matching entry is dropped with no flag change. A stored value of 0x00 matches like any other value.
- R2: When `dec_en` is 1, a word is kept only if `rx_word[8]` equals `dec_bit9` and `rx_word[9]` equals `dec_bit10`.
- R3: A word is stored only when every enabled check passes. With both checks disabled, every strobed word is stored.
- R4: Stored words are returned in arrival order, and the FIFO holds up to 32 words.
- R5: A word accepted while the FIFO holds 32 words replaces the newest entry, and no word is popped for it.
- R6: `rx_ready` is 1 when at least one word is held, `rx_half` when at least 16 are held and `rx_full` when 32 are held. All three are valid in the cycle after the strobe or read that changes the count.
- R7: A read strobe with `host_sel`=0 returns `rx_word[15:0]` of the head word, and with `host_sel`=1 it returns `rx_word[31:16]`. The data is on `host_rdata` in the cycle after the strobe. The head word is popped once both halves have been read, in either order. Reading the same half again does not pop.
- R8: After `lbl_mode` rises, the next 16 host writes store `host_wdata` into table entries 1 to 16 in order. Further writes are ignored until `lbl_mode` falls and rises again.
- R9: While `lbl_mode` is 1, strobed words are never stored.
- R10: While `lbl_mode` is 1 and `lbl_match_en` is 0, the first 16 reads after the mode rises return entries 1 to 16 on bits 7:0 with bits 15:8 zero. Any later read returns zero. No read in label mode touches the FIFO.
- R11: Reset empties the FIFO and clears the flags. The label table keeps its contents.
- R12: After reset, `rx_ready`, `rx_half`, `rx_full` and `host_rdata` are all 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| rx_valid | input | 1 | End-of-word strobe from the validator |
| rx_word | input | 32 | Completed word, serial bit 1 in bit 0 |
| lbl_mode | input | 1 | Label table load/readback mode |
| lbl_match_en | input | 1 | Enable label matching |
| dec_en | input | 1 | Enable the bit 9/10 check |
| dec_bit9 | input | 1 | Required value of serial bit 9 |
| dec_bit10 | input | 1 | Required value of serial bit 10 |
| host_rd | input | 1 | Host read strobe |
| host_sel | input | 1 | Half select: 0 low half, 1 high half |
| host_wr | input | 1 | Host label write strobe |
| host_wdata | input | 8 | Label value to write |
| host_rdata | output | 16 | Registered read data |
| rx_ready | output | 1 | FIFO holds at least one word |
| rx_half | output | 1 | FIFO holds 16 or more words |
| rx_full | output | 1 | FIFO holds 32 words |

## Verification
Every result is due exactly one clock after its stimulus. A strobe seen at a rising edge updates the count register at that edge, and the flags follow from the count. A read strobe loads `host_rdata` at the same edge. A rising `lbl_mode` resets the table sequence at the first edge that sees it, so the bench waits one full cycle before the first label access. The bench drives each strobe for one cycle starting at a falling edge, removes it at the next falling edge and samples the outputs there. This puts each check half a period after the edge that produced the result.

// File: rtl/rxf_pkg.sv
// Shared constants and helpers for the label filter / receive FIFO.
// Assumes serial bit 1 sits in bit 0 of a word.
package rxf_pkg;
    localparam int WORD_W = 32;
    localparam int HALF_W = 16;
    localparam int LBL_W  = 8;

    // Pick one 16-bit half of a stored word.
    function automatic logic [HALF_W-1:0] half_of(input logic [WORD_W-1:0] w,
                                                   input logic sel);
        return sel ? w[WORD_W-1:HALF_W] : w[HALF_W-1:0];
    endfunction
endpackage

// File: rtl/rxf_label_store.sv
// Label table with sequenced load and readback.
// A rising mode bit restarts both sequence counters. Each counter then
// serves N accesses and stops until the next rising edge.
// The table itself has no reset, so its contents survive a master reset.
module rxf_label_store #(
    parameter int N  = 16,
    parameter int LW = 8
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          mode,
    input  logic          host_wr,
    input  logic [LW-1:0] wr_data,
    input  logic          host_rd,
    input  logic          rd_allow,
    input  logic [LW-1:0] rx_label,
    output logic          hit,
    output logic [LW-1:0] rd_label
);
    localparam int AW = (N > 1) ? $clog2(N) : 1;
    localparam int IW = $clog2(N + 1);
    localparam logic [IW-1:0] LAST = IW'(N);

    logic [LW-1:0] tbl [N];
    logic          mode_q;
    logic [IW-1:0] wr_idx, rd_idx;
    logic          start, wr_go, rd_go;
    logic [N-1:0]  match;

    assign start = mode & ~mode_q;
    assign wr_go = mode & ~start & host_wr & (wr_idx < LAST);
    assign rd_go = mode & ~start & host_rd & rd_allow & (rd_idx < LAST);

    // Sequence counters: restart on a rising mode bit, count accesses after it.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            mode_q <= 1'b0;
            wr_idx <= LAST;
            rd_idx <= LAST;
        end else begin
            mode_q <= mode;
            if (start) begin
                wr_idx <= '0;
                rd_idx <= '0;
            end else begin
                if (wr_go) wr_idx <= wr_idx + IW'(1);
                if (rd_go) rd_idx <= rd_idx + IW'(1);
            end
        end
    end

    // Table storage: written only by the load sequence.
    always_ff @(posedge clk) begin
        if (wr_go) tbl[wr_idx[AW-1:0]] <= wr_data;
    end

    assign rd_label = rd_go ? tbl[rd_idx[AW-1:0]] : '0;

    // Compare the incoming label against every entry in parallel.
    for (genvar g = 0; g < N; g++) begin : g_cmp
        assign match[g] = (tbl[g] == rx_label);
    end
    assign hit = |match;

    // R8
    idx_range_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_idx <= LAST) && (rd_idx <= LAST));
    // R8
    seq_restart_chk: assert property (@(posedge clk) disable iff (!rst_n)
        start |=> (wr_idx == '0) && (rd_idx == '0));
endmodule

// File: rtl/rxf_filter.sv
// Acceptance check for a completed word.
// Combines the label hit, the bit 9/10 check and the label-mode suspend.
// Purely combinational; the hit comes from the label store.
module rxf_filter (
    input  logic        word_valid,
    input  logic [31:0] word,
    input  logic        label_mode,
    input  logic        lbl_en,
    input  logic        dec_en,
    input  logic        dec_b9,
    input  logic        dec_b10,
    input  logic        hit,
    output logic        accept
);
    logic lbl_ok, dec_ok;

    // Each check passes trivially when disabled.
    always_comb begin
        lbl_ok = ~lbl_en | hit;
        dec_ok = ~dec_en | ((word[8] == dec_b9) && (word[9] == dec_b10));
        accept = word_valid & ~label_mode & lbl_ok & dec_ok;
    end
endmodule

// File: rtl/rxf_fifo.sv
// Word FIFO that overwrites its newest entry when a push arrives while full.
// Assumes DEPTH is a power of two so that the pointers wrap naturally.
// A pop request on an empty FIFO is ignored.
module rxf_fifo #(
    parameter int DEPTH = 32,
    parameter int W     = 32
) (
    input  logic                       clk,
    input  logic                       rst_n,
    input  logic                       push,
    input  logic [W-1:0]               din,
    input  logic                       pop,
    output logic [W-1:0]               dout,
    output logic [$clog2(DEPTH+1)-1:0] count
);
    localparam int AW = $clog2(DEPTH);
    localparam int CW = $clog2(DEPTH + 1);
    localparam logic [CW-1:0] FULL_C = CW'(DEPTH);

    logic [W-1:0]  mem [DEPTH];
    logic [AW-1:0] wr_ptr, rd_ptr;
    logic          full, do_pop, over, push_new;

    assign full     = (count == FULL_C);
    assign do_pop   = pop & (count != '0);
    assign over     = push & full & ~do_pop;
    assign push_new = push & ~over;

    // Pointer and occupancy bookkeeping.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            wr_ptr <= '0;
            rd_ptr <= '0;
            count  <= '0;
        end else begin
            if (push_new) wr_ptr <= wr_ptr + AW'(1);
            if (do_pop)   rd_ptr <= rd_ptr + AW'(1);
            if (push_new && !do_pop)      count <= count + CW'(1);
            else if (!push_new && do_pop) count <= count - CW'(1);
        end
    end

    // Storage: normal pushes take the next slot, overflow rewrites the newest.
    always_ff @(posedge clk) begin
        if (over)          mem[wr_ptr - AW'(1)] <= din;
        else if (push_new) mem[wr_ptr] <= din;
    end

    assign dout = mem[rd_ptr];

    // R6
    count_bound_chk: assert property (@(posedge clk) disable iff (!rst_n)
        count <= FULL_C);
    // R5
    overwrite_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (push && full && !pop) |=> (count == FULL_C));
    // R4
    push_grow_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (push && !full && !pop) |=> (count == $past(count) + CW'(1)));
    // R7
    pop_shrink_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (pop && (count != '0) && !push) |=> (count == $past(count) - CW'(1)));
endmodule

// File: rtl/rxf_label_fifo.sv
// Top level: label filter feeding a receive FIFO with two-half host reads.
// Assumes the control bits are steady around word strobes. Host strobes
// last one cycle each.
module rxf_label_fifo #(
    parameter int DEPTH  = 32,
    parameter int LABELS = 16
) (
    input  logic        clk,
    input  logic        rst_n,
    input  logic        rx_valid,
    input  logic [31:0] rx_word,
    input  logic        lbl_mode,
    input  logic        lbl_match_en,
    input  logic        dec_en,
    input  logic        dec_bit9,
    input  logic        dec_bit10,
    input  logic        host_rd,
    input  logic        host_sel,
    input  logic        host_wr,
    input  logic [7:0]  host_wdata,
    output logic [15:0] host_rdata,
    output logic        rx_ready,
    output logic        rx_half,
    output logic        rx_full
);
    import rxf_pkg::*;

    localparam int CW = $clog2(DEPTH + 1);
    localparam logic [CW-1:0] FULL_C = CW'(DEPTH);
    localparam logic [CW-1:0] HALF_C = CW'(DEPTH / 2);

    logic              hit, push, fifo_rd, fifo_pop;
    logic [LBL_W-1:0]  lbl_rd;
    logic [WORD_W-1:0] head;
    logic [CW-1:0]     count;
    logic [1:0]        half_seen, seen_next;

    rxf_label_store #(.N(LABELS), .LW(LBL_W)) u_store (
        .clk      (clk),
        .rst_n    (rst_n),
        .mode     (lbl_mode),
        .host_wr  (host_wr),
        .wr_data  (host_wdata),
        .host_rd  (host_rd),
        .rd_allow (~lbl_match_en),
        .rx_label (rx_word[LBL_W-1:0]),
        .hit      (hit),
        .rd_label (lbl_rd)
    );

    rxf_filter u_filter (
        .word_valid (rx_valid),
        .word       (rx_word),
        .label_mode (lbl_mode),
        .lbl_en     (lbl_match_en),
        .dec_en     (dec_en),
        .dec_b9     (dec_bit9),
        .dec_b10    (dec_bit10),
        .hit        (hit),
        .accept     (push)
    );

    rxf_fifo #(.DEPTH(DEPTH), .W(WORD_W)) u_fifo (
        .clk   (clk),
        .rst_n (rst_n),
        .push  (push),
        .din   (rx_word),
        .pop   (fifo_pop),
        .dout  (head),
        .count (count)
    );

    assign fifo_rd   = host_rd & ~lbl_mode & (count != '0);
    assign seen_next = half_seen | (host_sel ? 2'b10 : 2'b01);
    assign fifo_pop  = fifo_rd & (&seen_next);

    // Track which halves of the head word the host has already taken.
    always_ff @(posedge clk) begin
        if (!rst_n)       half_seen <= 2'b00;
        else if (fifo_rd) half_seen <= fifo_pop ? 2'b00 : seen_next;
    end

    // Read data register: label readback in label mode, else a FIFO half.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            host_rdata <= '0;
        end else if (host_rd) begin
            if (lbl_mode)     host_rdata <= {{(HALF_W-LBL_W){1'b0}}, lbl_rd};
            else if (fifo_rd) host_rdata <= half_of(head, host_sel);
            else              host_rdata <= '0;
        end
    end

    assign rx_ready = (count != '0);
    assign rx_half  = (count >= HALF_C);
    assign rx_full  = (count == FULL_C);

    // R9
    suspend_chk: assert property (@(posedge clk) disable iff (!rst_n)
        lbl_mode |-> !push);
    // R7
    pop_needs_pair_chk: assert property (@(posedge clk) disable iff (!rst_n)
        fifo_pop |-> (half_seen != 2'b00));
    // R6
    flag_order_chk: assert property (@(posedge clk) disable iff (!rst_n)
        rx_full |-> (rx_half && rx_ready));
    // R10
    label_read_keeps_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (lbl_mode && host_rd && !rx_valid) |=> $stable(rx_ready));
endmodule

// File: tb/rxf_label_fifo_bench.sv
module rxf_label_fifo_bench;
    logic        clk = 1'b0;
    logic        rst_n;
    logic        rx_valid, lbl_mode, lbl_match_en, dec_en, dec_bit9, dec_bit10;
    logic        host_rd, host_sel, host_wr;
    logic [31:0] rx_word;
    logic [7:0]  host_wdata;
    logic [15:0] host_rdata;
    logic        rx_ready, rx_half, rx_full;

    int   n_tests = 0;
    int   n_fail  = 0;
    logic [31:0] w, got;
    logic [15:0] h0, h1;

    always #10 clk = ~clk;

    rxf_label_fifo u_rxf_label_fifo (
        .clk(clk), .rst_n(rst_n), .rx_valid(rx_valid), .rx_word(rx_word),
        .lbl_mode(lbl_mode), .lbl_match_en(lbl_match_en), .dec_en(dec_en),
        .dec_bit9(dec_bit9), .dec_bit10(dec_bit10), .host_rd(host_rd),
        .host_sel(host_sel), .host_wr(host_wr), .host_wdata(host_wdata),
        .host_rdata(host_rdata), .rx_ready(rx_ready), .rx_half(rx_half),
        .rx_full(rx_full)
    );

    task automatic chk(input bit ok, input string req, input logic [31:0] act,
                       input logic [31:0] exp);
        n_tests++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic summary();
        $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
    endtask

    task automatic do_reset();
        @(negedge clk);
        rst_n = 1'b0;
        repeat (2) @(negedge clk);
        rst_n = 1'b1;
    endtask

    task automatic send(input logic [31:0] v);
        @(negedge clk);
        rx_valid = 1'b1;
        rx_word  = v;
        @(negedge clk);
        rx_valid = 1'b0;
    endtask

    task automatic rd_half(input logic s, output logic [15:0] d);
        @(negedge clk);
        host_rd  = 1'b1;
        host_sel = s;
        @(negedge clk);
        host_rd  = 1'b0;
        d = host_rdata;
    endtask

    task automatic wr_label(input logic [7:0] v);
        @(negedge clk);
        host_wr    = 1'b1;
        host_wdata = v;
        @(negedge clk);
        host_wr    = 1'b0;
    endtask

    task automatic set_mode(input logic m);
        @(negedge clk);
        lbl_mode = m;
        @(negedge clk);
    endtask

    task automatic read_word(output logic [31:0] v);
        logic [15:0] a, b;
        rd_half(1'b0, a);
        rd_half(1'b1, b);
        v = {b, a};
    endtask

    function automatic logic [7:0] lbl_of(input int i);
        return 8'(i * 17);
    endfunction

    initial begin
        repeat (150000) @(posedge clk);
        n_tests++;
        n_fail++;
        $display("FAIL watchdog actual=%h expected=%h", 32'h0, 32'h1);
        summary();
        $finish;
    end

    initial begin
        rst_n = 1'b0; rx_valid = 0; rx_word = '0; lbl_mode = 0; lbl_match_en = 0;
        dec_en = 0; dec_bit9 = 0; dec_bit10 = 0; host_rd = 0; host_sel = 0;
        host_wr = 0; host_wdata = '0;
        do_reset();
        // R12 reset state
        chk({rx_ready, rx_half, rx_full} == 3'b000, "R12 flags", {29'h0, rx_ready, rx_half, rx_full}, 0);
        chk(host_rdata == 16'h0, "R12 rdata", {16'h0, host_rdata}, 0);

        // R8 load 16 labels plus one extra write that must be ignored
        set_mode(1'b1);
        for (int i = 0; i < 16; i++) wr_label(lbl_of(i));
        wr_label(8'hAA);
        set_mode(1'b0);
        // R10 readback in order, then zero
        set_mode(1'b1);
        for (int i = 0; i < 16; i++) begin
            rd_half(1'b1, h0);
            chk(h0 == {8'h00, lbl_of(i)}, "R8 R10 label readback", {16'h0, h0}, {24'h0, lbl_of(i)});
        end
        rd_half(1'b1, h0);
        chk(h0 == 16'h0, "R10 read past end", {16'h0, h0}, 0);
        set_mode(1'b0);

        // R1 label sweep over all 256 values, table holds multiples of 17
        lbl_match_en = 1'b1;
        for (int l = 0; l < 256; l++) begin
            w = {8'(l) ^ 8'h3C, 8'hA5, ~8'(l), 8'(l)};
            send(w);
            chk(rx_ready == ((l % 17) == 0), "R1 label match", {31'h0, rx_ready}, {31'h0, 1'((l % 17) == 0)});
            if ((l % 17) == 0) begin
                read_word(got);
                chk(got == w, "R1 R7 word data", got, w);
                chk(!rx_ready, "R7 pop after both halves", {31'h0, rx_ready}, 0);
            end
        end

        // R2 bit 9/10 check sweep
        lbl_match_en = 1'b0;
        dec_en = 1'b1;
        for (int c = 0; c < 4; c++) begin
            for (int b = 0; b < 4; b++) begin
                dec_bit9  = c[0];
                dec_bit10 = c[1];
                w = {16'h1234, 6'h0, 2'(b), 8'h77};
                send(w);
                chk(rx_ready == (b == c), "R2 decoder", {31'h0, rx_ready}, {31'h0, 1'(b == c)});
                if (b == c) begin
                    read_word(got);
                    chk(got == w, "R2 word data", got, w);
                end
            end
        end

        // R3 both checks on: bit9=0, bit10=1
        lbl_match_en = 1'b1;
        dec_bit9 = 1'b0; dec_bit10 = 1'b1;
        send({16'hBEEF, 6'h0, 2'b10, 8'h23});
        chk(!rx_ready, "R3 label fails", {31'h0, rx_ready}, 0);
        send({16'hBEEF, 6'h0, 2'b01, 8'h22});
        chk(!rx_ready, "R3 decoder fails", {31'h0, rx_ready}, 0);
        w = {16'hBEEF, 6'h0, 2'b10, 8'h22};
        send(w);
        chk(rx_ready, "R3 both pass", {31'h0, rx_ready}, 1);
        read_word(got);
        chk(got == w, "R3 word data", got, w);

        // R3 both disabled: every word stored
        lbl_match_en = 1'b0;
        dec_en = 1'b0;
        for (int i = 0; i < 4; i++) send(32'h5000_0301 + 32'(i));
        for (int i = 0; i < 4; i++) begin
            read_word(got);
            chk(got == 32'h5000_0301 + 32'(i), "R3 unfiltered", got, 32'h5000_0301 + 32'(i));
        end

        // R4 R5 R6 fill to 32, then overflow
        for (int i = 0; i < 33; i++) begin
            send((i == 32) ? 32'hDEAD_BEEF : (32'hF000_0000 | 32'(i)));
            if (i == 14 || i == 15 || i == 30 || i == 31 || i == 32) begin
                chk(rx_half == (i >= 15), "R6 half flag", {31'h0, rx_half}, {31'h0, 1'(i >= 15)});
                chk(rx_full == (i >= 31), "R6 full flag", {31'h0, rx_full}, {31'h0, 1'(i >= 31)});
            end
        end
        // R7 high half first
        rd_half(1'b1, h1);
        rd_half(1'b0, h0);
        chk({h1, h0} == 32'hF000_0000, "R7 reverse order", {h1, h0}, 32'hF000_0000);
        chk(!rx_full, "R6 full clears", {31'h0, rx_full}, 0);
        for (int i = 1; i < 32; i++) begin
            read_word(got);
            chk(got == ((i == 31) ? 32'hDEAD_BEEF : (32'hF000_0000 | 32'(i))), "R4 R5 order", got,
                (i == 31) ? 32'hDEAD_BEEF : (32'hF000_0000 | 32'(i)));
            if (i == 16) chk(!rx_half, "R6 half clears", {31'h0, rx_half}, 0);
        end
        chk(!rx_ready, "R6 empty", {31'h0, rx_ready}, 0);

        // R7 same half twice does not pop
        send(32'hCAFE_1357);
        rd_half(1'b0, h0);
        rd_half(1'b0, h1);
        chk(h1 == 16'h1357 && rx_ready, "R7 repeated half", {h1, 15'h0, rx_ready}, {16'h1357, 16'h1});
        rd_half(1'b1, h1);
        chk(h1 == 16'hCAFE, "R7 high half", {16'h0, h1}, 32'hCAFE);
        chk(!rx_ready, "R7 popped", {31'h0, rx_ready}, 0);

        // R9 R10 label mode: reads leave FIFO alone, words not stored
        send(32'h0BAD_F00D);
        set_mode(1'b1);
        rd_half(1'b0, h0);
        chk(h0 == {8'h0, lbl_of(0)}, "R10 label read", {16'h0, h0}, {24'h0, lbl_of(0)});
        chk(rx_ready, "R10 FIFO untouched", {31'h0, rx_ready}, 1);
        send(32'h1111_2222);
        set_mode(1'b0);
        read_word(got);
        chk(got == 32'h0BAD_F00D, "R10 head intact", got, 32'h0BAD_F00D);
        chk(!rx_ready, "R9 word suspended", {31'h0, rx_ready}, 0);

        // R11 reset clears FIFO, keeps labels
        for (int i = 0; i < 17; i++) send(32'h7700_0000 | 32'(i));
        do_reset();
        chk({rx_ready, rx_half, rx_full} == 3'b000, "R11 flags cleared", {29'h0, rx_ready, rx_half, rx_full}, 0);
        chk(host_rdata == 16'h0, "R12 rdata after reset", {16'h0, host_rdata}, 0);
        set_mode(1'b1);
        for (int i = 0; i < 16; i++) begin
            rd_half(1'b0, h0);
            chk(h0 == {8'h0, lbl_of(i)}, "R11 labels kept", {16'h0, h0}, {24'h0, lbl_of(i)});
        end
        set_mode(1'b0);

        summary();
        $finish;
    end
endmodule